// File: doc/BRIEF.md
# Keystream Generator Key-Setup Sequencer

This block prepares a four-register combination keystream generator for use. After a start strobe it clears the generator and feeds it a serial stream built from a 128-bit session key, a 48-bit device address, 26 clock bits and a 6-bit constant. Each register's linear feedback is switched on only after a delay equal to that register's own length. It then keeps stepping the generator until 200 output bits have come out, and reloads the last 128 of them as the new register contents. The carry state of the nonlinear combiner is left as it was at that moment.

The generator has four shift registers of lengths 25, 31, 33 and 39 and a combiner with four bits of state. It sits inside the block, and its register contents and combiner state are brought out so that the next stage can take over a prepared generator. A start/busy/ready handshake frames the procedure. One setup takes 202 clock edges from the accepting edge to the first cycle with ready high.

Top module: `ks_key_setup`

## Requirements
- R1: After reset, busy and ready are low, and lfsr_state, comb_state and stream_bit are zero. A start strobe accepted while idle or ready clears all four registers and the combiner state at the accepting edge, and latches key_in, addr_in and clkb_in.
- R2: Each register has its own serial input stream, fed least significant bit first, one bit per step, with a zero input after the stream ends. Key byte j is key_in[8j+7:8j], address byte j is addr_in[8j+7:8j], and the constant is 6'b110001. Register 0 (25 bits) gets key bytes 0,4,8,12, then address byte 2, then clkb_in[15:8], then clkb_in[24]. Register 1 (31 bits) gets key bytes 1,5,9,13, then address bytes 0 and 3, then clkb_in[3:0], then constant bits [2:0]. Register 2 (33 bits) gets key bytes 2,6,10,14, then address byte 4, then clkb_in[23:16], then clkb_in[25]. Register 3 (39 bits) gets key bytes 3,7,11,15, then address bytes 1 and 5, then clkb_in[7:4], then constant bits [5:3].
- R3: Register i of length L shifts upward: the new bit enters bit 0. The new bit is the stream bit, XORed with the feedback when feedback is on. Feedback is bit L-1 XOR three taps: {19,11,7}, {23,15,11}, {27,23,3} and {35,27,3} for registers 0..3. Feedback is on from the step whose zero-based index equals L, so each register first takes L steps with feedback open. The register output bits are bits 23, 23, 31 and 31. lfsr_state is {reg3, reg2, reg1, reg0}.
- R4: The combiner state is forced to zero by each of the first 39 steps, so comb_state reads zero up to and including the state after step 39.
- R5: The combiner sum is the count of ones among the four register output bits plus the current value cur (0..3). stream_bit is the sum mod 2. With u the sum divided by 2, a normal step sets cur to u XOR cur XOR T(prev) and prev to the old cur, where T({h,l}) = {l, h XOR l}. comb_state is {prev, cur}.
- R6: Exactly 200 steps are taken, and outputs 72..199 form bytes Z[0]..Z[15], output 72 being bit 0 of Z[0]. The reload writes reg0 = {Z12[0], Z8, Z4, Z0}, reg1 = {Z12[7:1], Z9, Z5, Z1}, reg2 = {Z15[0], Z13, Z10, Z6, Z2} and reg3 = {Z15[7:1], Z14, Z11, Z7, Z3}, each with the most significant part first.
- R7: The reload edge leaves comb_state unchanged.
- R8: busy is high from the accepting edge through the reload edge (201 cycles). ready rises at the reload edge, and busy and ready are never both high.
- R9: A start strobe while busy has no effect on the sequence or its result.
- R10: ready and the prepared state hold until the next start strobe, which begins a fresh setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe |
| key_in | input | 128 | Session key |
| addr_in | input | 48 | Device address |
| clkb_in | input | 26 | Clock bits |
| busy | output | 1 | Setup in progress |
| ready | output | 1 | Generator prepared |
| lfsr_state | output | 128 | Register contents {reg3, reg2, reg1, reg0} |
| comb_state | output | 4 | Combiner state {prev, cur} |
| stream_bit | output | 1 | Current generator output bit |

## Verification
The assertions check on every cycle the framing of the sequence. They cover the zero combiner state during the first 39 steps, the step count at reload, a combiner left untouched by the reload, ready holding until a start, and a start while busy not restarting the count. Only the bench scenarios can show that the bit streams, tap positions, feedback switch-on times, combiner arithmetic and reload byte mapping give the right numbers. To do so, the bench compares every output bit, a snapshot after 40 steps and the final state against an arithmetic model, for several input patterns.

// File: rtl/ks_setup_pkg.sv
package ks_setup_pkg;
    localparam int NUM_REG      = 4;
    localparam int KEY_W        = 128;
    localparam int ADDR_W       = 48;
    localparam int CLKB_W       = 26;
    localparam int SALT_W       = 6;
    localparam int TOTAL_SYMS   = 200;
    localparam int KEEP_SYMS    = 128;
    localparam int CAPTURE_FROM = TOTAL_SYMS - KEEP_SYMS;
    localparam int ZERO_STEPS   = 39;
    localparam int STREAM_MAX   = 55;
    localparam int CNT_W        = 8;
    localparam int STATE_W      = 128;

    localparam int REG_LEN    [NUM_REG] = '{25, 31, 33, 39};
    localparam int REG_OFF    [NUM_REG] = '{0, 25, 56, 89};
    localparam int STREAM_LEN [NUM_REG] = '{49, 55, 49, 55};
    localparam int TAP_A      [NUM_REG] = '{19, 23, 27, 35};
    localparam int TAP_B      [NUM_REG] = '{11, 15, 23, 27};
    localparam int TAP_C      [NUM_REG] = '{7, 11, 3, 3};
    localparam int OUT_TAP    [NUM_REG] = '{23, 23, 31, 31};

    typedef enum logic [2:0] {
        ST_IDLE, ST_SHIFT, ST_MIX, ST_RELOAD, ST_READY
    } seq_state_e;

    typedef struct packed {
        logic [1:0] prev;
        logic [1:0] cur;
    } comb_state_t;

    typedef logic [NUM_REG-1:0][STREAM_MAX-1:0] stream_set_t;

    function automatic logic [1:0] scramble_prev(logic [1:0] p);
        return {p[0], p[1] ^ p[0]};
    endfunction

    function automatic logic [2:0] comb_sum(comb_state_t c, logic [NUM_REG-1:0] x);
        return 3'(x[0]) + 3'(x[1]) + 3'(x[2]) + 3'(x[3]) + 3'(c.cur);
    endfunction

    function automatic comb_state_t comb_next(comb_state_t c, logic [NUM_REG-1:0] x);
        comb_state_t n;
        logic [2:0]  s;
        s      = comb_sum(c, x);
        n.prev = c.cur;
        n.cur  = s[2:1] ^ c.cur ^ scramble_prev(c.prev);
        return n;
    endfunction

    function automatic stream_set_t build_streams(logic [KEY_W-1:0] k, logic [ADDR_W-1:0] a,
                                                  logic [CLKB_W-1:0] cb, logic [SALT_W-1:0] salt);
        stream_set_t s;
        s    = '0;
        s[0] = STREAM_MAX'({cb[24], cb[15:8], a[23:16],
                            k[103:96], k[71:64], k[39:32], k[7:0]});
        s[1] = STREAM_MAX'({salt[2:0], cb[3:0], a[31:24], a[7:0],
                            k[111:104], k[79:72], k[47:40], k[15:8]});
        s[2] = STREAM_MAX'({cb[25], cb[23:16], a[39:32],
                            k[119:112], k[87:80], k[55:48], k[23:16]});
        s[3] = STREAM_MAX'({salt[5:3], cb[7:4], a[47:40], a[15:8],
                            k[127:120], k[95:88], k[63:56], k[31:24]});
        return s;
    endfunction

    // Captured outputs (bit 0 = earliest kept output) to packed register image.
    function automatic logic [STATE_W-1:0] reload_image(logic [KEEP_SYMS-1:0] zb);
        return {zb[127:121], zb[119:112], zb[95:88], zb[63:56], zb[31:24],
                zb[120], zb[111:104], zb[87:80], zb[55:48], zb[23:16],
                zb[103:97], zb[79:72], zb[47:40], zb[15:8],
                zb[96], zb[71:64], zb[39:32], zb[7:0]};
    endfunction
endpackage

// File: rtl/ks_lfsr.sv
module ks_lfsr #(
    parameter int LEN     = 25,
    parameter int TAP1    = 19,
    parameter int TAP2    = 11,
    parameter int TAP3    = 7,
    parameter int OUT_POS = 23
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           step,
    input  logic           fb_on,
    input  logic           din,
    input  logic           load,
    input  logic [LEN-1:0] load_val,
    output logic [LEN-1:0] q,
    output logic           xo
);
    logic fb;

    assign fb = q[LEN-1] ^ q[TAP1] ^ q[TAP2] ^ q[TAP3];
    assign xo = q[OUT_POS];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (step) begin
            q <= {q[LEN-2:0], din ^ (fb_on & fb)};
        end
    end
endmodule

// File: rtl/ks_combiner.sv
module ks_combiner
    import ks_setup_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               step,
    input  logic               force_zero,
    input  logic [NUM_REG-1:0] x,
    output logic               z,
    output comb_state_t        state
);
    logic [2:0] sum;

    assign sum = comb_sum(state, x);
    assign z   = sum[0];

    always_ff @(posedge clk) begin
        if (rst || clr || (step && force_zero)) begin
            state <= '0;
        end else if (step) begin
            state <= comb_next(state, x);
        end
    end
endmodule

// File: rtl/ks_init_fsm.sv
module ks_init_fsm
    import ks_setup_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             ready,
    output logic             clr,
    output logic             step,
    output logic             load,
    output logic [CNT_W-1:0] cnt,
    output seq_state_e       phase
);
    seq_state_e st_q, st_d;
    logic       accept;

    assign accept = start && (st_q == ST_IDLE || st_q == ST_READY);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE, ST_READY: if (accept) st_d = ST_SHIFT;
            ST_SHIFT:  if (cnt == CNT_W'(STREAM_MAX - 1)) st_d = ST_MIX;
            ST_MIX:    if (cnt == CNT_W'(TOTAL_SYMS - 1)) st_d = ST_RELOAD;
            ST_RELOAD: st_d = ST_READY;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            cnt  <= '0;
        end else begin
            st_q <= st_d;
            if (accept) cnt <= '0;
            else if (step) cnt <= cnt + 1'b1;
        end
    end

    assign step  = (st_q == ST_SHIFT) || (st_q == ST_MIX);
    assign busy  = step || (st_q == ST_RELOAD);
    assign ready = (st_q == ST_READY);
    assign load  = (st_q == ST_RELOAD);
    assign clr   = accept;
    assign phase = st_q;

    // R9: a start during stepping never restarts the count
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (step && start) |=> (cnt != '0));

    // R10: ready persists without a start
    assert_ready_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> ready);

    // R6: reload only after exactly the full symbol count
    assert_reload_count_R6: assert property (@(posedge clk) disable iff (rst)
        load |-> (cnt == CNT_W'(TOTAL_SYMS)));
endmodule

// File: rtl/ks_key_setup.sv
module ks_key_setup
    import ks_setup_pkg::*;
#(
    parameter logic [SALT_W-1:0] SALT = 6'b110001
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [KEY_W-1:0]    key_in,
    input  logic [ADDR_W-1:0]   addr_in,
    input  logic [CLKB_W-1:0]   clkb_in,
    output logic                busy,
    output logic                ready,
    output logic [STATE_W-1:0]  lfsr_state,
    output logic [3:0]          comb_state,
    output logic                stream_bit
);
    logic             clr, step, load;
    logic [CNT_W-1:0] cnt;
    seq_state_e       phase;
    stream_set_t      streams_q;
    logic [KEEP_SYMS-1:0] zcap_q;
    logic [STATE_W-1:0]   reload_val;
    logic [NUM_REG-1:0]   xbits;
    comb_state_t          cstate;

    ks_init_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .ready(ready),
        .clr(clr), .step(step), .load(load), .cnt(cnt), .phase(phase)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            streams_q <= '0;
            zcap_q    <= '0;
        end else begin
            if (clr) streams_q <= build_streams(key_in, addr_in, clkb_in, SALT);
            if (step && cnt >= CNT_W'(CAPTURE_FROM)) zcap_q <= {stream_bit, zcap_q[KEEP_SYMS-1:1]};
        end
    end

    assign reload_val = reload_image(zcap_q);

    for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
        localparam int L = REG_LEN[g];
        logic [L-1:0] q;
        logic         din, fb_on;

        assign din   = (cnt < CNT_W'(STREAM_LEN[g])) ? streams_q[g][cnt[5:0]] : 1'b0;
        assign fb_on = (cnt >= CNT_W'(L));

        ks_lfsr #(
            .LEN(L), .TAP1(TAP_A[g]), .TAP2(TAP_B[g]), .TAP3(TAP_C[g]), .OUT_POS(OUT_TAP[g])
        ) u_lfsr (
            .clk(clk), .rst(rst), .clr(clr), .step(step), .fb_on(fb_on), .din(din),
            .load(load), .load_val(reload_val[REG_OFF[g] +: L]), .q(q), .xo(xbits[g])
        );

        assign lfsr_state[REG_OFF[g] +: L] = q;
    end

    ks_combiner u_comb (
        .clk(clk), .rst(rst), .clr(clr), .step(step),
        .force_zero(cnt < CNT_W'(ZERO_STEPS)),
        .x(xbits), .z(stream_bit), .state(cstate)
    );

    assign comb_state = cstate;

    // R4: combiner held at zero through the first 39 steps
    assert_comb_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_SHIFT && cnt <= CNT_W'(ZERO_STEPS)) |-> (comb_state == 4'd0));

    // R7: reload edge keeps the combiner state
    assert_comb_kept_R7: assert property (@(posedge clk) disable iff (rst)
        $past(load) |-> (comb_state == $past(comb_state)));

    // R8: ready only rises out of the reload cycle, never together with busy
    assert_ready_entry_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ($past(load) && !busy));
endmodule

// File: tb/ks_key_setup_tb.sv
module ks_key_setup_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [127:0] key_in = '0;
    logic [47:0]  addr_in = '0;
    logic [25:0]  clkb_in = '0;
    logic         busy, ready, stream_bit;
    logic [127:0] lfsr_state;
    logic [3:0]   comb_state;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ks_key_setup u_dut (
        .clk(clk), .rst(rst), .start(start), .key_in(key_in), .addr_in(addr_in),
        .clkb_in(clkb_in), .busy(busy), .ready(ready), .lfsr_state(lfsr_state),
        .comb_state(comb_state), .stream_bit(stream_bit)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            checks++;
            $display("FAIL watchdog act=%0d exp<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Arithmetic reference built from the requirements.
    task automatic model(input logic [127:0] k, input logic [47:0] a, input logic [25:0] cb,
                         output logic [127:0] st, output logic [3:0] cs,
                         output logic [199:0] zs, output logic [127:0] snap);
        logic [54:0] s [4];
        logic [38:0] r [4];
        int rl [4]  = '{25, 31, 33, 39};
        int sl [4]  = '{49, 55, 49, 55};
        int ta [4]  = '{19, 23, 27, 35};
        int tb [4]  = '{11, 15, 23, 27};
        int tc [4]  = '{7, 11, 3, 3};
        int ot [4]  = '{23, 23, 31, 31};
        logic [5:0] salt = 6'b110001;
        logic [1:0] cc, cp, nc, u;
        logic [127:0] zb;
        s[0] = 55'({cb[24], cb[15:8], a[23:16], k[103:96], k[71:64], k[39:32], k[7:0]});
        s[1] = 55'({salt[2:0], cb[3:0], a[31:24], a[7:0], k[111:104], k[79:72], k[47:40], k[15:8]});
        s[2] = 55'({cb[25], cb[23:16], a[39:32], k[119:112], k[87:80], k[55:48], k[23:16]});
        s[3] = 55'({salt[5:3], cb[7:4], a[47:40], a[15:8], k[127:120], k[95:88], k[63:56], k[31:24]});
        for (int i = 0; i < 4; i++) r[i] = '0;
        cc = '0; cp = '0; snap = '0;
        for (int t = 0; t < 200; t++) begin
            int sum;
            sum = int'(cc);
            for (int i = 0; i < 4; i++) sum += int'(r[i][ot[i]]);
            zs[t] = sum[0];
            u = 2'(sum >> 1);
            if (t < 39) begin
                cc = '0; cp = '0;
            end else begin
                nc = u ^ cc ^ {cp[0], cp[1] ^ cp[0]};
                cp = cc; cc = nc;
            end
            for (int i = 0; i < 4; i++) begin
                logic fb, din;
                fb  = r[i][rl[i]-1] ^ r[i][ta[i]] ^ r[i][tb[i]] ^ r[i][tc[i]];
                din = (t < sl[i]) ? s[i][t] : 1'b0;
                r[i] = ((r[i] << 1) | 39'(din ^ ((t >= rl[i]) ? fb : 1'b0))) & ((39'd1 << rl[i]) - 39'd1);
            end
            if (t == 39) snap = {r[3][38:0], r[2][32:0], r[1][30:0], r[0][24:0]};
        end
        zb = zs[199:72];
        st = {zb[127:121], zb[119:112], zb[95:88], zb[63:56], zb[31:24],
              zb[120], zb[111:104], zb[87:80], zb[55:48], zb[23:16],
              zb[103:97], zb[79:72], zb[47:40], zb[15:8],
              zb[96], zb[71:64], zb[39:32], zb[7:0]};
        cs = {cp, cc};
    endtask

    task automatic run(input logic [127:0] k, input logic [47:0] a, input logic [25:0] cb, input bit poke);
        logic [127:0] est, esnap;
        logic [3:0]   ecs;
        logic [199:0] ezs;
        int zbad = 0, cbad = 0, bbad = 0;
        model(k, a, cb, est, ecs, ezs, esnap);
        @(negedge clk);
        key_in = k; addr_in = a; clkb_in = cb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        key_in = ~k; addr_in = ~a; clkb_in = ~cb;   // latched at start; later changes ignored
        for (int n = 0; n <= 200; n++) begin
            if (n > 0) @(negedge clk);
            if (n < 200 && stream_bit !== ezs[n]) zbad++;
            if (n <= 39 && comb_state !== 4'd0) cbad++;
            if (busy !== 1'b1 || ready !== 1'b0) bbad++;
            if (n == 40) chk(lfsr_state === esnap, "R3 state after 40 steps", lfsr_state, esnap);
            if (poke && n == 100) start = 1'b1;
            if (poke && n == 101) start = 1'b0;
        end
        chk(zbad == 0, "R5 output bit trace mismatches", 128'(zbad), 128'd0);
        chk(cbad == 0, "R4 combiner zero in first 39 steps", 128'(cbad), 128'd0);
        chk(bbad == 0, "R8 busy for 201 cycles", 128'(bbad), 128'd0);
        @(negedge clk);
        chk(ready === 1'b1 && busy === 1'b0, "R8 ready after reload", {busy, ready}, 2'b01);
        chk(lfsr_state === est, poke ? "R9 result after ignored start" : "R2 R6 reloaded state",
            lfsr_state, est);
        chk(comb_state === ecs, "R7 combiner kept at reload", comb_state, ecs);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && ready === 1'b0, "R1 reset handshake", {busy, ready}, 2'b00);
        chk(lfsr_state === '0 && comb_state === '0 && stream_bit === 1'b0, "R1 reset state",
            {comb_state, stream_bit, lfsr_state[122:0]}, 128'd0);

        run('0, '0, '0, 1'b0);
        begin
            logic [127:0] hold_st;
            hold_st = lfsr_state;
            repeat (5) @(negedge clk);
            chk(ready === 1'b1 && busy === 1'b0, "R10 ready holds", {busy, ready}, 2'b01);
            chk(lfsr_state === hold_st, "R10 state holds", lfsr_state, hold_st);
        end
        run('1, '1, '1, 1'b1);
        run(128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0, 48'h0123456789ab, 26'h2aaaaaa, 1'b0);
        for (int i = 1; i <= 4; i++) begin
            logic [127:0] k;
            logic [31:0]  h;
            h = 32'(i) * 32'h9e3779b9;
            k = {h ^ 32'h85ebca6b, h + 32'hc2b2ae35, ~h, h};
            run(k, {h[15:0], h}, 26'(h >> 3), i == 2);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule